// File: doc/BRIEF.md
# Multichannel DAC Code Gain and Offset Trim

This block sits in front of an eight-channel digital-to-analog converter. It corrects each raw 16-bit code before it is sent to the converter. Every channel has its own gain word and its own offset word. The corrected code follows a straight line: the input is scaled by the channel's gain word, then shifted by the channel's offset word, and the result is limited to the 16-bit code range. Two coarse 14-bit group offset words each cover four channels. The block does no arithmetic on them. Each corrected code leaves the block with the group word that applies to its channel, so a downstream converter stage can use it.

Codes enter with a valid flag and a channel number. The result appears two clock cycles later, with the same flag and channel number. The trim words are loaded through a single-cycle write port. That port takes a selector, an index and a data word.

Top module: `dac_trim_core`

## Requirements
- R1: After reset every gain word is 65535 and every offset word is 32768, so each channel returns its input code unchanged (out = in for 0, 12345 and 65535).
- R2: With the gain word at 65535, an offset word of 32768+k gives out = in + k, and an offset word of 32768−k gives out = in − k, when the result lies within 0..65535.
- R3: The output saturates at 65535 and never wraps. With the offset word at 33536 and unity gain, inputs 64767 through 65535 all give 65535, and input 64766 gives 65534.
- R4: A result below zero clamps to 0. With the offset word at 32268, inputs 499 and 500 give 0 and input 501 gives 1.
- R5: The scaled value is floor(in × (gain+1) / 65536). With the gain word at 63999, input 65535 gives 63999, input 32768 gives 32000, and input 1 gives 0.
- R6: An input accepted at clock edge k appears on the outputs after edge k+1. outValid is high for exactly one cycle per accepted input, and outChan equals the input channel. Inputs on consecutive cycles give consecutive results.
- R7: Both group offset words reset to 8192. Group 0 serves channels 0–3 and group 1 serves channels 4–7, chosen by channel bit 2. outGroupOfs carries the word of the result's group. A group word is written with selector 2 and index 0 or 1, from wrData bits 13:0.
- R8: Writes that name no register have no effect: gain (selector 0) or offset (selector 1) with index 8–15, group (selector 2) with index 2–15, and selector 3 with any index.
- R9: A write takes effect for an input accepted on the next cycle or later. An input accepted on the same edge as the write uses the old value.
- R10: A write to one channel's gain or offset word changes the results of that channel only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the trim words |
| wrSel | input | 2 | Target: 0 gain, 1 offset, 2 group offset, 3 reserved |
| wrChan | input | 4 | Channel index (or group index for selector 2) |
| wrData | input | 16 | Write data; group words use bits 13:0 |
| inValid | input | 1 | Input code valid |
| inChan | input | 3 | Channel of the input code |
| inCode | input | 16 | Raw input code |
| outValid | output | 1 | Corrected code valid |
| outChan | output | 3 | Channel of the corrected code |
| outCode | output | 16 | Corrected, saturated code |
| outGroupOfs | output | 14 | Group offset word for outChan's group |

## Verification
Two cases are the hardest to reach from the ports. The first is the edge where a trim write and an input for the same channel meet. The bench raises the write and the input on the same edge and checks that the old word was used. It then sends a second input on the very next edge and checks that the new word was used. The second case is the saturation boundary. The bench reaches it by loading an offset 768 steps above mid-scale. It then walks the input across 64766, 64767 and 64768, and does the same across the zero clamp with a negative offset.

// File: rtl/dac_trim_pkg.sv
package dac_trim_pkg;
  parameter int TRIM_CH         = 8;
  parameter int TRIM_CODE_W     = 16;
  parameter int TRIM_GRP_W      = 14;
  parameter int TRIM_CH_PER_GRP = 4;

  localparam int TRIM_NUM_GRP  = TRIM_CH / TRIM_CH_PER_GRP;
  localparam int CH_W          = $clog2(TRIM_CH);
  localparam int WR_IDX_W      = CH_W + 1;
  localparam int GRP_SHIFT     = $clog2(TRIM_CH_PER_GRP);
  localparam int GRP_IDX_W     = (TRIM_NUM_GRP > 1) ? $clog2(TRIM_NUM_GRP) : 1;
  localparam int SUM_W         = TRIM_CODE_W + 3;
  localparam int MUL_W         = 2 * TRIM_CODE_W;

  localparam logic [TRIM_CODE_W-1:0] GAIN_UNITY = '1;
  localparam logic [TRIM_CODE_W-1:0] OFFS_MID   = TRIM_CODE_W'(1) << (TRIM_CODE_W - 1);
  localparam logic [TRIM_GRP_W-1:0]  GRP_MID    = TRIM_GRP_W'(1) << (TRIM_GRP_W - 1);

  typedef enum logic [1:0] {
    SEL_GAIN  = 2'd0,
    SEL_OFFS  = 2'd1,
    SEL_GROUP = 2'd2,
    SEL_RSVD  = 2'd3
  } trimSel_e;

  typedef struct packed {
    logic                   wrGain;
    logic                   wrOffs;
    logic                   wrGroup;
    logic [CH_W-1:0]        idx;
    logic [TRIM_CODE_W-1:0] data;
  } trimStrobe_t;
endpackage

// File: rtl/dac_trim_ctrl.sv
module dac_trim_ctrl
  import dac_trim_pkg::*;
(
  input  logic                   wrEn,
  input  logic [1:0]             wrSel,
  input  logic [WR_IDX_W-1:0]    wrChan,
  input  logic [TRIM_CODE_W-1:0] wrData,
  output trimStrobe_t            strb
);
  trimSel_e selDec;
  logic     chanOk;
  logic     grpOk;

  always_comb begin
    selDec = trimSel_e'(wrSel);
    chanOk = (int'(wrChan) < TRIM_CH);
    grpOk  = (int'(wrChan) < TRIM_NUM_GRP);

    strb.wrGain  = wrEn && (selDec == SEL_GAIN)  && chanOk;
    strb.wrOffs  = wrEn && (selDec == SEL_OFFS)  && chanOk;
    strb.wrGroup = wrEn && (selDec == SEL_GROUP) && grpOk;
    strb.idx     = wrChan[CH_W-1:0];
    strb.data    = wrData;
  end
endmodule

// File: rtl/dac_trim_path.sv
module dac_trim_path
  import dac_trim_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  trimStrobe_t            strb,
  input  logic                   inValid,
  input  logic [CH_W-1:0]        inChan,
  input  logic [TRIM_CODE_W-1:0] inCode,
  output logic                   outValid,
  output logic [CH_W-1:0]        outChan,
  output logic [TRIM_CODE_W-1:0] outCode,
  output logic [TRIM_GRP_W-1:0]  outGroupOfs
);
  logic [TRIM_CODE_W-1:0] gainReg [TRIM_CH];
  logic [TRIM_CODE_W-1:0] offsReg [TRIM_CH];
  logic [TRIM_GRP_W-1:0]  grpReg  [TRIM_NUM_GRP];

  // trim register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TRIM_CH; i++) begin
        gainReg[i] <= GAIN_UNITY;
        offsReg[i] <= OFFS_MID;
      end
      for (int g = 0; g < TRIM_NUM_GRP; g++) grpReg[g] <= GRP_MID;
    end else begin
      if (strb.wrGain)  gainReg[strb.idx] <= strb.data;
      if (strb.wrOffs)  offsReg[strb.idx] <= strb.data;
      if (strb.wrGroup) grpReg[strb.idx[GRP_IDX_W-1:0]] <= strb.data[TRIM_GRP_W-1:0];
    end
  end

  // stage 1: scale
  logic [TRIM_CODE_W-1:0] gainSel;
  logic [TRIM_CODE_W:0]   gainPlus;
  logic [MUL_W-1:0]       mulFull;
  logic [TRIM_CODE_W-1:0] prodNext;
  logic [GRP_IDX_W-1:0]   grpIdx;

  always_comb begin
    gainSel  = gainReg[inChan];
    gainPlus = {1'b0, gainSel} + 1'b1;
    mulFull  = MUL_W'(inCode) * MUL_W'(gainPlus);
    prodNext = TRIM_CODE_W'(mulFull >> TRIM_CODE_W);
    grpIdx   = GRP_IDX_W'(inChan >> GRP_SHIFT);
  end

  logic                   v1;
  logic [CH_W-1:0]        ch1;
  logic [TRIM_CODE_W-1:0] prod1;
  logic [TRIM_CODE_W-1:0] c1;
  logic [TRIM_GRP_W-1:0]  g1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1    <= 1'b0;
      ch1   <= '0;
      prod1 <= '0;
      c1    <= OFFS_MID;
      g1    <= GRP_MID;
    end else begin
      v1 <= inValid;
      if (inValid) begin
        ch1   <= inChan;
        prod1 <= prodNext;
        c1    <= offsReg[inChan];
        g1    <= grpReg[grpIdx];
      end
    end
  end

  // stage 2: offset and clamp
  logic signed [SUM_W-1:0] sumFull;
  logic [TRIM_CODE_W-1:0]  clampVal;
  localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'({TRIM_CODE_W{1'b1}});

  always_comb begin
    sumFull = $signed(SUM_W'(prod1)) + $signed(SUM_W'(c1)) - $signed(SUM_W'(OFFS_MID));
    if (sumFull < 0)             clampVal = '0;
    else if (sumFull > CODE_MAX) clampVal = '1;
    else                         clampVal = sumFull[TRIM_CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outChan     <= '0;
      outCode     <= '0;
      outGroupOfs <= GRP_MID;
    end else begin
      outValid <= v1;
      if (v1) begin
        outChan     <= ch1;
        outCode     <= clampVal;
        outGroupOfs <= g1;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2)); // R6

  AST_CHAN_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outChan == $past(inChan, 2)); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(c1 >= OFFS_MID) |-> outCode >= $past(prod1)); // R3

  AST_LOW_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(({1'b0, prod1} + {1'b0, c1}) < {1'b0, OFFS_MID}) |-> outCode == '0); // R4

  for (genvar i = 0; i < TRIM_CH; i++) begin : g_hold
    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.wrGain && strb.idx == CH_W'(i)) |=> $stable(gainReg[i])); // R8
    AST_OFFS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.wrOffs && strb.idx == CH_W'(i)) |=> $stable(offsReg[i])); // R10
  end
endmodule

// File: rtl/dac_trim_core.sv
module dac_trim_core
  import dac_trim_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [1:0]             wrSel,
  input  logic [WR_IDX_W-1:0]    wrChan,
  input  logic [TRIM_CODE_W-1:0] wrData,
  input  logic                   inValid,
  input  logic [CH_W-1:0]        inChan,
  input  logic [TRIM_CODE_W-1:0] inCode,
  output logic                   outValid,
  output logic [CH_W-1:0]        outChan,
  output logic [TRIM_CODE_W-1:0] outCode,
  output logic [TRIM_GRP_W-1:0]  outGroupOfs
);
  trimStrobe_t strb;

  dac_trim_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrChan (wrChan),
    .wrData (wrData),
    .strb   (strb)
  );

  dac_trim_path u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .inValid     (inValid),
    .inChan      (inChan),
    .inCode      (inCode),
    .outValid    (outValid),
    .outChan     (outChan),
    .outCode     (outCode),
    .outGroupOfs (outGroupOfs)
  );
endmodule

// File: tb/dac_trim_core_bench.sv
`timescale 1ns/1ps
module dac_trim_core_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [3:0]  wrChan = '0;
  logic [15:0] wrData = '0;
  logic        inValid = 1'b0;
  logic [2:0]  inChan = '0;
  logic [15:0] inCode = '0;
  logic        outValid;
  logic [2:0]  outChan;
  logic [15:0] outCode;
  logic [13:0] outGroupOfs;

  int total = 0;
  int bad = 0;
  int mdlM [8];
  int mdlC [8];
  int mdlG [2];

  always #4 clk = ~clk;

  dac_trim_core u_dac_trim_core (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrChan(wrChan),
    .wrData(wrData), .inValid(inValid), .inChan(inChan), .inCode(inCode),
    .outValid(outValid), .outChan(outChan), .outCode(outCode),
    .outGroupOfs(outGroupOfs)
  );

  function automatic int model(int x, int m, int c);
    longint p;
    longint s;
    p = (longint'(x) * longint'(m + 1)) / 65536;
    s = p + longint'(c) - 32768;
    if (s < 0) s = 0;
    if (s > 65535) s = 65535;
    return int'(s);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mdlWrite(int sel, int ch, int data);
    if (sel == 0 && ch < 8) mdlM[ch] = data;
    if (sel == 1 && ch < 8) mdlC[ch] = data;
    if (sel == 2 && ch < 2) mdlG[ch] = data & 16'h3fff;
  endtask

  task automatic writeReg(int sel, int ch, int data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'(sel); wrChan = 4'(ch); wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
    mdlWrite(sel, ch, data);
  endtask

  task automatic sendCode(string tag, int ch, int x, int expOverride = -1);
    int exp;
    exp = (expOverride >= 0) ? expOverride : model(x, mdlM[ch], mdlC[ch]);
    @(negedge clk);
    inValid = 1'b1; inChan = 3'(ch); inCode = 16'(x);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    chk({tag, " valid"}, int'(outValid), 1);
    chk({tag, " code"}, int'(outCode), exp);
    chk({tag, " chan"}, int'(outChan), ch);
    chk({tag, " group"}, int'(outGroupOfs), mdlG[ch / 4]);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 reset outValid", int'(outValid), 0);
    chk("R7 reset group word", int'(outGroupOfs), 8192);
  endtask

  task automatic testPassThrough();
    sendCode("R1 ch0 x=0", 0, 0, 0);
    sendCode("R1 ch0 x=12345", 0, 12345, 12345);
    sendCode("R1 ch7 x=65535", 7, 65535, 65535);
  endtask

  task automatic testOffset();
    writeReg(1, 2, 32768 + 100);
    sendCode("R2 +100", 2, 1000, 1100);
    writeReg(1, 2, 32768 - 50);
    sendCode("R2 -50", 2, 1000, 950);
    sendCode("R10 ch0 unaffected", 0, 1000, 1000);
  endtask

  task automatic testSaturate();
    writeReg(1, 3, 33536);
    sendCode("R3 x=64766", 3, 64766, 65534);
    sendCode("R3 x=64767", 3, 64767, 65535);
    sendCode("R3 x=64768", 3, 64768, 65535);
    sendCode("R3 x=65535", 3, 65535, 65535);
  endtask

  task automatic testLowClamp();
    writeReg(1, 3, 32268);
    sendCode("R4 x=499", 3, 499, 0);
    sendCode("R4 x=500", 3, 500, 0);
    sendCode("R4 x=501", 3, 501, 1);
  endtask

  task automatic testGain();
    writeReg(0, 5, 63999);
    sendCode("R5 x=65535", 5, 65535, 63999);
    sendCode("R5 x=32768", 5, 32768, 32000);
    sendCode("R5 x=1", 5, 1, 0);
    sendCode("R5 x=50000", 5, 50000);
    sendCode("R10 ch4 unity", 4, 50000, 50000);
  endtask

  task automatic testWriteTiming();
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'd0; wrChan = 4'd1; wrData = 16'd32767;
    inValid = 1'b1; inChan = 3'd1; inCode = 16'd40000;
    @(negedge clk);
    wrEn = 1'b0;
    mdlWrite(0, 1, 32767);
    inCode = 16'd40000;
    @(negedge clk);
    inValid = 1'b0;
    chk("R9 same-edge old gain", int'(outCode), 40000);
    @(negedge clk);
    chk("R9 next-edge new gain valid", int'(outValid), 1);
    chk("R9 next-edge new gain", int'(outCode), 20000);
  endtask

  task automatic testPipeline();
    @(negedge clk);
    inValid = 1'b1; inChan = 3'd4; inCode = 16'd10;
    @(negedge clk);
    inChan = 3'd7; inCode = 16'd20;
    @(negedge clk);
    inValid = 1'b0;
    chk("R6 first valid", int'(outValid), 1);
    chk("R6 first chan", int'(outChan), 4);
    chk("R6 first code", int'(outCode), 10);
    @(negedge clk);
    chk("R6 second valid", int'(outValid), 1);
    chk("R6 second chan", int'(outChan), 7);
    chk("R6 second code", int'(outCode), 20);
    @(negedge clk);
    chk("R6 single-cycle valid", int'(outValid), 0);
  endtask

  task automatic testIgnored();
    writeReg(0, 8, 0);
    sendCode("R8 gain idx 8 ignored", 0, 30000, 30000);
    writeReg(1, 15, 0);
    sendCode("R8 offset idx 15 ignored", 7, 30000, 30000);
    writeReg(2, 2, 0);
    sendCode("R8 group idx 2 ignored", 4, 5, 5);
    writeReg(3, 0, 0);
    sendCode("R8 selector 3 ignored", 0, 777, 777);
  endtask

  task automatic testGroup();
    writeReg(2, 1, 16'h1234);
    sendCode("R7 group1 on ch6", 6, 100, 100);
    sendCode("R7 group0 on ch2", 2, 100);
    writeReg(2, 0, 16'hffff);
    sendCode("R7 group0 14-bit write", 1, 100);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      mdlM[i] = 65535;
      mdlC[i] = 32768;
    end
    mdlG[0] = 8192;
    mdlG[1] = 8192;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPassThrough();
    testOffset();
    testSaturate();
    testLowClamp();
    testGain();
    testWriteTiming();
    testPipeline();
    testIgnored();
    testGroup();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule